// File: doc/BRIEF.md
# Bit-Band Alias Translator

This block is a bus slave that stands in front of a larger memory map. Each 32 MB alias window it decodes maps every aligned 4-byte word in the window to one single bit of a real memory region. A read through the alias returns that bit as a clean 0 or 1. A write through the alias changes only that bit. To do so it reads the enclosing byte, halfword or word from the backing memory on a master port, updates the bit and writes the unit back.

The default build serves two windows. Real region 0x2000_0000 sits behind the alias at 0x2200_0000, and real region 0x4000_0000 sits behind the alias at 0x4200_0000. The region count, base, stride, alias gap and window size are all parameters. The slave port takes one access at a time. It holds ready low until the whole sequence on the master port has finished, so a bit update cannot be split by a second alias access.

Top module: `bb_bitband_xlat`

## Requirements
- R1: While reset is held low and in the cycle after it is released, s_ready and m_valid are 0.
- R2: An alias address lies in region r when its bits [31:25] equal those of base0 + r*stride + 0x0200_0000, with base0 = 0x2000_0000 and stride = 0x2000_0000. The real byte address is the region's real base OR (alias & 0x01FF_FFFF) >> 5.
- R3: s_size = 0 selects a byte access. The master address is the real byte address, the bit index is alias bits [4:2], and m_size = 0.
- R4: s_size = 1 selects a halfword access. The master address has bit 0 cleared and the bit index is alias bits [5:2]. Unit data is right-justified and little-endian on m_rdata/m_wdata, so bit n lies in byte n/8 of the unit.
- R5: s_size = 2 selects a word access. The master address has bits [1:0] cleared and the bit index is alias bits [6:2].
- R6: A read completes with s_rdata[0] equal to the selected bit of the fetched unit and s_rdata[31:1] = 0. It issues exactly one master read and no master write.
- R7: A write issues one master read, then one master write to the same address and size. The written unit equals the fetched unit with only the selected bit changed, and m_wdata bits above the unit size are 0. s_rdata is 0 when a write completes.
- R8: Only s_wdata[0] matters: 1 sets the bit and 0 clears it. All other s_wdata bits have no effect on the written unit.
- R9: s_ready is a one-cycle pulse that comes only after the final master transfer of the access has been accepted. The master port is idle while s_ready is high.
- R10: An access outside every alias window completes with s_rdata = 0 and makes no master request.
- R11: A master request keeps m_valid, m_write, m_size, m_addr and m_wdata stable until m_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Slave request, held until s_ready |
| s_ready | output | 1 | One-cycle completion pulse |
| s_write | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word |
| s_addr | input | 32 | Alias address |
| s_wdata | input | 32 | Write data, bit 0 used |
| s_rdata | output | 32 | Read result, valid with s_ready |
| m_valid | output | 1 | Master request valid |
| m_ready | input | 1 | Master request accepted |
| m_write | output | 1 | Master request is a write |
| m_size | output | 2 | Master unit size, same code as s_size |
| m_addr | output | 32 | Master byte address of the unit |
| m_wdata | output | 32 | Right-justified unit to write |
| m_rvalid | input | 1 | Read data valid |
| m_rdata | input | 32 | Right-justified unit read data |

## Verification
The bench builds the block with its default parameters: two regions, a 2^25-byte window and a 32-bit data path. This puts both alias windows in reach, along with the first and last alias words of each window and addresses just outside them. The backing model fills the unused upper bytes of every read return with a nonzero value, which exposes any unit masking error in the read-modify-write path. It also stalls each master request for one cycle, so a request that changes before it is accepted is caught.

// File: rtl/bb_pkg.sv
package bb_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_WR_REQ,
      ST_DONE
   } state_e;
endpackage

// File: rtl/bb_region_dec.sv
module bb_region_dec #(
   parameter int unsigned       ADDR_W        = 32,
   parameter int unsigned       NUM_REGIONS   = 2,
   parameter logic [ADDR_W-1:0] REAL_BASE0    = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] REGION_STRIDE = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] ALIAS_GAP     = 32'h0200_0000,
   parameter int unsigned       WIN_LOG2      = 25,
   parameter int unsigned       SHIFT         = 5
) (
   input  logic [ADDR_W-1:0] alias_addr,
   output logic              hit,
   output logic [ADDR_W-1:0] real_addr
);
   localparam logic [ADDR_W-1:0] WIN_MASK = (ADDR_W'(1) << WIN_LOG2) - ADDR_W'(1);

   logic [NUM_REGIONS-1:0] hit_vec;
   logic [ADDR_W-1:0]      cand [NUM_REGIONS];

   if (WIN_LOG2 >= ADDR_W) begin : g_bad_win
      $error("window must be smaller than the address space");
   end
   if (NUM_REGIONS < 1) begin : g_bad_cnt
      $error("at least one region is required");
   end

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
      localparam logic [ADDR_W-1:0] REAL_B  = REAL_BASE0 + ADDR_W'(r) * REGION_STRIDE;
      localparam logic [ADDR_W-1:0] ALIAS_B = REAL_B + ALIAS_GAP;
      assign hit_vec[r] = (alias_addr >> WIN_LOG2) == (ALIAS_B >> WIN_LOG2);
      assign cand[r]    = hit_vec[r] ? (REAL_B | ((alias_addr & WIN_MASK) >> SHIFT)) : '0;
   end

   always_comb begin
      real_addr = '0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
         real_addr = real_addr | cand[r];
      end
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/bb_lane.sv
module bb_lane
   import bb_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic [ADDR_W-1:0]         real_addr,
   input  size_e                     size,
   input  logic [ADDR_W-1:0]         alias_addr,
   output logic [ADDR_W-1:0]         unit_addr,
   output logic [$clog2(DATA_W)-1:0] bit_idx
);
   localparam int unsigned IDX_W   = $clog2(DATA_W);
   localparam int unsigned SEL_LSB = $clog2(DATA_W / 8);

   logic [IDX_W-1:0]  idx_mask;
   logic [ADDR_W-1:0] align_mask;

   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
      $error("data width must be a power of two of at least 32");
   end

   always_comb begin
      unique case (size)
         SZ_BYTE: begin
            idx_mask   = IDX_W'(7);
            align_mask = '0;
         end
         SZ_HALF: begin
            idx_mask   = IDX_W'(15);
            align_mask = ADDR_W'(1);
         end
         default: begin
            idx_mask   = IDX_W'(31);
            align_mask = ADDR_W'(3);
         end
      endcase
   end

   assign unit_addr = real_addr & ~align_mask;
   assign bit_idx   = alias_addr[SEL_LSB +: IDX_W] & idx_mask;
endmodule

// File: rtl/bb_bitop.sv
module bb_bitop
   import bb_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0]         rdata,
   input  size_e                     size,
   input  logic [$clog2(DATA_W)-1:0] bit_idx,
   input  logic                      set_val,
   output logic                      bit_val,
   output logic [DATA_W-1:0]         new_unit
);
   logic [DATA_W-1:0] unit_mask;
   logic [DATA_W-1:0] sel;
   logic [DATA_W-1:0] unit;

   always_comb begin
      unique case (size)
         SZ_BYTE: unit_mask = DATA_W'(32'h0000_00FF);
         SZ_HALF: unit_mask = DATA_W'(32'h0000_FFFF);
         default: unit_mask = DATA_W'(32'hFFFF_FFFF);
      endcase
   end

   assign sel      = DATA_W'(1) << bit_idx;
   assign unit     = rdata & unit_mask;
   assign bit_val  = |(unit & sel);
   assign new_unit = set_val ? (unit | sel) : (unit & ~sel);
endmodule

// File: rtl/bb_seq.sv
module bb_seq
   import bb_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      s_valid,
   input  logic                      s_write,
   input  logic                      s_wbit,
   input  logic                      hit,
   input  logic [ADDR_W-1:0]         unit_addr,
   input  size_e                     size,
   input  logic [$clog2(DATA_W)-1:0] bit_idx,
   input  logic                      m_ready,
   input  logic                      m_rvalid,
   input  logic                      bit_val,
   input  logic [DATA_W-1:0]         new_unit,
   output logic                      s_ready,
   output logic                      s_bit,
   output logic                      m_valid,
   output logic                      m_write,
   output logic [ADDR_W-1:0]         m_addr,
   output size_e                     size_q,
   output logic [$clog2(DATA_W)-1:0] idx_q,
   output logic                      wbit_q,
   output logic [DATA_W-1:0]         m_wdata,
   output state_e                    state
);
   logic              write_q;
   logic              bit_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         write_q <= 1'b0;
         wbit_q  <= 1'b0;
         bit_q   <= 1'b0;
         addr_q  <= '0;
         size_q  <= SZ_BYTE;
         idx_q   <= '0;
         wdata_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (s_valid) begin
                  addr_q  <= unit_addr;
                  size_q  <= size;
                  idx_q   <= bit_idx;
                  write_q <= s_write;
                  wbit_q  <= s_wbit;
                  bit_q   <= 1'b0;
                  state   <= hit ? ST_RD_REQ : ST_DONE;
               end
            end
            ST_RD_REQ: begin
               if (m_ready) state <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (m_rvalid) begin
                  bit_q   <= bit_val;
                  wdata_q <= new_unit;
                  state   <= write_q ? ST_WR_REQ : ST_DONE;
               end
            end
            ST_WR_REQ: begin
               if (m_ready) state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign s_ready = (state == ST_DONE);
   assign s_bit   = bit_q & ~write_q;
   assign m_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
   assign m_write = (state == ST_WR_REQ);
   assign m_addr  = addr_q;
   assign m_wdata = wdata_q;
endmodule

// File: rtl/bb_bitband_xlat.sv
module bb_bitband_xlat
   import bb_pkg::*;
#(
   parameter int unsigned       ADDR_W        = 32,
   parameter int unsigned       DATA_W        = 32,
   parameter int unsigned       NUM_REGIONS   = 2,
   parameter logic [ADDR_W-1:0] REAL_BASE0    = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] REGION_STRIDE = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] ALIAS_GAP     = 32'h0200_0000,
   parameter int unsigned       WIN_LOG2      = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic              s_write,
   input  logic [1:0]        s_size,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] s_rdata,
   output logic              m_valid,
   input  logic              m_ready,
   output logic              m_write,
   output logic [1:0]        m_size,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata,
   input  logic              m_rvalid,
   input  logic [DATA_W-1:0] m_rdata
);
   localparam int unsigned IDX_W = $clog2(DATA_W);
   localparam int unsigned SHIFT = $clog2(DATA_W);

   logic              hit;
   logic [ADDR_W-1:0] real_addr;
   logic [ADDR_W-1:0] unit_addr;
   logic [IDX_W-1:0]  bit_idx;
   logic [IDX_W-1:0]  idx_q;
   size_e             size_q;
   logic              wbit_q;
   logic              bit_val;
   logic              s_bit;
   logic [DATA_W-1:0] new_unit;
   state_e            fsm_state;
   logic              wdata_unused;

   assign wdata_unused = ^s_wdata[DATA_W-1:1];

   bb_region_dec #(
      .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .REAL_BASE0(REAL_BASE0),
      .REGION_STRIDE(REGION_STRIDE), .ALIAS_GAP(ALIAS_GAP),
      .WIN_LOG2(WIN_LOG2), .SHIFT(SHIFT)
   ) u_dec (
      .alias_addr(s_addr), .hit(hit), .real_addr(real_addr)
   );

   bb_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
      .real_addr(real_addr), .size(size_e'(s_size)), .alias_addr(s_addr),
      .unit_addr(unit_addr), .bit_idx(bit_idx)
   );

   bb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_write(s_write),
      .s_wbit(s_wdata[0]), .hit(hit), .unit_addr(unit_addr),
      .size(size_e'(s_size)), .bit_idx(bit_idx), .m_ready(m_ready),
      .m_rvalid(m_rvalid), .bit_val(bit_val), .new_unit(new_unit),
      .s_ready(s_ready), .s_bit(s_bit), .m_valid(m_valid), .m_write(m_write),
      .m_addr(m_addr), .size_q(size_q), .idx_q(idx_q), .wbit_q(wbit_q),
      .m_wdata(m_wdata), .state(fsm_state)
   );

   bb_bitop #(.DATA_W(DATA_W)) u_bitop (
      .rdata(m_rdata), .size(size_q), .bit_idx(idx_q), .set_val(wbit_q),
      .bit_val(bit_val), .new_unit(new_unit)
   );

   assign m_size  = size_q;
   assign s_rdata = {{(DATA_W-1){1'b0}}, s_bit};
endmodule

// File: rtl/bb_xlat_chk.sv
module bb_xlat_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ready,
   input logic [DATA_W-1:0] s_rdata,
   input logic              m_valid,
   input logic              m_ready,
   input logic              m_write,
   input logic [1:0]        m_size,
   input logic [ADDR_W-1:0] m_addr,
   input logic [DATA_W-1:0] m_wdata
);
   // R9: completion is a single-cycle pulse
   assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> !s_ready);

   // R9: master port idle while the slave completes
   assert_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> !m_valid);

   // R11: request held until accepted
   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)
                                 && $stable(m_size) && $stable(m_wdata)));

   // R4: halfword units are 2-byte aligned
   assert_half_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_size == 2'd1) |-> (m_addr[0] == 1'b0));

   // R5: word units are 4-byte aligned
   assert_word_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_size == 2'd2) |-> (m_addr[1:0] == 2'b00));

   // R6: result carries one bit only
   assert_rdata_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (s_rdata[DATA_W-1:1] == '0));

   // R7: written byte unit has clean upper bits
   assert_wdata_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_write && m_size == 2'd0) |-> (m_wdata[DATA_W-1:8] == '0));

   // R7: written halfword unit has clean upper bits
   assert_wdata_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_write && m_size == 2'd1) |-> (m_wdata[DATA_W-1:16] == '0));
endmodule

bind bb_bitband_xlat bb_xlat_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .s_rdata(s_rdata),
   .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_size(m_size),
   .m_addr(m_addr), .m_wdata(m_wdata)
);

// File: tb/test_bb_bitband_xlat.sv
module test_bb_bitband_xlat;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        s_valid, s_ready, s_write;
   logic [1:0]  s_size;
   logic [31:0] s_addr, s_wdata, s_rdata;
   logic        m_valid, m_ready, m_write, m_rvalid;
   logic [1:0]  m_size;
   logic [31:0] m_addr, m_wdata, m_rdata;

   always #5 clk = ~clk;

   bb_bitband_xlat i_bb_bitband_xlat (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .s_write(s_write), .s_size(s_size), .s_addr(s_addr), .s_wdata(s_wdata),
      .s_rdata(s_rdata), .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
      .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid),
      .m_rdata(m_rdata)
   );

   typedef struct {
      string       tag;
      logic [31:0] exp_rdata;
      int          exp_rd;
      int          exp_wr;
      logic [31:0] exp_addr;
      logic [1:0]  exp_size;
      logic [31:0] exp_wdata;
   } item_t;

   item_t       sb[$];
   logic [7:0]  mem [logic [31:0]];
   int          n_rd, n_wr, checks, fails;
   logic [31:0] rd_addr, wr_addr, wr_data;
   logic [1:0]  rd_size, wr_size;
   bit          finished;

   function automatic logic [7:0] mbyte(logic [31:0] a);
      return mem.exists(a) ? mem[a] : (a[7:0] ^ 8'h5A ^ a[15:8]);
   endfunction

   function automatic logic [31:0] unit_val(logic [31:0] a, logic [1:0] sz);
      logic [31:0] v = '0;
      for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = mbyte(a + 32'(i));
      return v;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // backing memory responder: stalls each request one cycle (R11)
   initial begin
      logic [31:0] ra, held;
      logic [1:0]  rs;
      bit          stall = 1'b0;
      m_ready = 1'b0; m_rvalid = 1'b0; m_rdata = '0;
      forever begin
         @(negedge clk);
         m_ready = 1'b0; m_rvalid = 1'b0;
         if (m_valid) begin
            if (!stall) begin
               stall = 1'b1;
               held  = m_addr;
            end else begin
               stall = 1'b0;
               chk("R11", "held address", m_addr, held);
               m_ready = 1'b1;
               if (m_write) begin
                  n_wr++; wr_addr = m_addr; wr_size = m_size; wr_data = m_wdata;
                  for (int i = 0; i < (1 << m_size); i++) mem[m_addr + 32'(i)] = m_wdata[8*i +: 8];
               end else begin
                  n_rd++; rd_addr = m_addr; rd_size = m_size;
                  ra = m_addr; rs = m_size;
                  @(negedge clk);
                  m_ready  = 1'b0;
                  m_rvalid = 1'b1;
                  m_rdata  = 32'hA5A5_A5A5;
                  for (int i = 0; i < (1 << rs); i++) m_rdata[8*i +: 8] = mbyte(ra + 32'(i));
               end
            end
         end
      end
   end

   // monitor: pops the scoreboard at each completion
   initial begin
      forever begin
         item_t it;
         @(negedge clk);
         if (s_ready) begin
            if (sb.size() == 0) begin
               checks++; fails++;
               $display("FAIL R9 unexpected completion: actual 1 expected 0");
            end else begin
               it = sb.pop_front();
               chk(it.tag, "rdata", s_rdata, it.exp_rdata);
               chk(it.tag, "master reads", 32'(n_rd), 32'(it.exp_rd));
               chk(it.tag, "master writes", 32'(n_wr), 32'(it.exp_wr));
               if (it.exp_rd != 0) begin
                  chk(it.tag, "read addr", rd_addr, it.exp_addr);
                  chk(it.tag, "read size", 32'(rd_size), 32'(it.exp_size));
               end
               if (it.exp_wr != 0) begin
                  chk(it.tag, "write addr", wr_addr, it.exp_addr);
                  chk(it.tag, "write size", 32'(wr_size), 32'(it.exp_size));
                  chk(it.tag, "write data", wr_data, it.exp_wdata);
               end
            end
         end
      end
   end

   task automatic acc(bit wr, logic [1:0] sz, logic [31:0] a, logic [31:0] wd, string tag);
      item_t       it;
      bit          hit = 1'b0;
      logic [31:0] base = '0, rb, ua, cur, sel;
      int          idx;
      if (a >= 32'h2200_0000 && a < 32'h2400_0000) begin hit = 1'b1; base = 32'h2000_0000; end
      if (a >= 32'h4200_0000 && a < 32'h4400_0000) begin hit = 1'b1; base = 32'h4000_0000; end
      rb  = base | ((a & 32'h01FF_FFFF) >> 5);
      ua  = rb & ~((32'd1 << sz) - 32'd1);
      idx = int'((a >> 2) & ((32'd8 << sz) - 32'd1));
      cur = unit_val(ua, sz);
      sel = 32'd1 << idx;
      it.tag       = tag;
      it.exp_rd    = hit ? 1 : 0;
      it.exp_wr    = (hit && wr) ? 1 : 0;
      it.exp_addr  = ua;
      it.exp_size  = sz;
      it.exp_wdata = wd[0] ? (cur | sel) : (cur & ~sel);
      it.exp_rdata = (hit && !wr) ? {31'd0, cur[idx]} : 32'd0;
      sb.push_back(it);
      @(negedge clk);
      n_rd = 0; n_wr = 0;
      s_valid = 1'b1; s_write = wr; s_size = sz; s_addr = a; s_wdata = wd;
      do @(negedge clk); while (!s_ready);
      s_valid = 1'b0; s_wdata = '0;
      @(negedge clk);
      chk("R9", "ready pulse width", 32'(s_ready), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R9 watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf = 32'h1234_5678;
      logic [31:0] a;
      logic [1:0]  sz;
      rst_n = 1'b0; s_valid = 1'b0; s_write = 1'b0; s_size = '0; s_addr = '0; s_wdata = '0;
      repeat (3) @(negedge clk);
      chk("R1", "s_ready in reset", 32'(s_ready), 32'd0);
      chk("R1", "m_valid in reset", 32'(m_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "s_ready after reset", 32'(s_ready), 32'd0);
      chk("R1", "m_valid after reset", 32'(m_valid), 32'd0);

      acc(1'b0, 2'd0, 32'h2200_0000, '0, "R3");
      acc(1'b0, 2'd0, 32'h2200_001C, '0, "R3");
      acc(1'b0, 2'd0, 32'h2200_0420, '0, "R3");
      acc(1'b0, 2'd1, 32'h2200_003C, '0, "R4");
      acc(1'b0, 2'd1, 32'h2200_0A64, '0, "R4");
      acc(1'b0, 2'd2, 32'h2200_007C, '0, "R5");
      acc(1'b0, 2'd2, 32'h4200_1234, '0, "R5");
      acc(1'b0, 2'd0, 32'h4200_0000, '0, "R6");
      acc(1'b0, 2'd2, 32'h23FF_FFFC, '0, "R2");
      acc(1'b0, 2'd0, 32'h43FF_FFFC, '0, "R2");

      acc(1'b1, 2'd0, 32'h2200_0104, 32'h1, "R7");
      acc(1'b0, 2'd0, 32'h2200_0104, '0, "R6");
      acc(1'b1, 2'd1, 32'h2200_0238, 32'h0, "R7");
      acc(1'b1, 2'd2, 32'h4200_027C, 32'h1, "R7");
      acc(1'b0, 2'd2, 32'h4200_027C, '0, "R6");
      acc(1'b1, 2'd2, 32'h4200_0280, 32'hFFFF_FFFE, "R8");
      acc(1'b1, 2'd1, 32'h2200_0300, 32'hFFFF_FFFF, "R8");
      acc(1'b1, 2'd0, 32'h2200_0300, 32'h8000_0000, "R8");
      acc(1'b0, 2'd0, 32'h2200_0300, '0, "R8");

      acc(1'b0, 2'd2, 32'h2400_0000, '0, "R10");
      acc(1'b0, 2'd0, 32'h21FF_FFFC, '0, "R10");
      acc(1'b1, 2'd1, 32'h3000_0010, 32'h1, "R10");
      acc(1'b1, 2'd2, 32'h4400_0000, 32'h1, "R10");

      for (int k = 0; k < 48; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         a  = (lf[3] ? 32'h4200_0000 : 32'h2200_0000) | (lf & 32'h0000_3FFC);
         sz = (lf[5:4] == 2'd3) ? 2'd2 : lf[5:4];
         acc(lf[6], sz, a, lf, "R2");
      end

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule